// File: doc/BRIEF.md
# Byte-Parallel Configuration Serializer

This block is the receiving end of a byte-wide configuration port that runs on a clock supplied by an outside host. While the port is enabled, the first rising edge latches a byte from the data bus. After that, a byte is latched on every eighth rising edge. Each latched byte leaves the block most significant bit first, one bit per clock, on a serial output. A one-cycle acknowledge follows every latched byte. A strobe warns the host during the cycle whose closing edge will take the bus.

A copy of the serial stream goes to a daisy-chain output, for a downstream device that shares the clock. This copy passes through one rising-edge stage and is then moved onto the falling edge. It therefore changes half a clock before the next device samples it on a rising edge.

A completion flag marks the end of the stream. It rises once a fixed tail of ten rising edges, plus one edge for each device further down the chain, has passed since the last byte was latched. The chain length is read from an input while reset is held.

Top module: `cfgser_top`

## Requirements
- R1: While `rst` is high and on the cycle after it, `ser_o`, `chain_o` and `done_o` are 0. With `init_done` high and `mode_sel` not 011, `ack_o` and `byte_stb` are 0 as well.
- R2: The port is enabled when `mode_sel` equals binary 011 and `init_done` is 1. The first rising edge with the port enabled latches `cfg_data`. Each later latch happens exactly eight rising edges after the previous one. `byte_stb` is 1 in exactly the cycles whose closing rising edge latches the bus.
- R3: `ack_o` is 1 for exactly the one clock cycle that follows each latching edge, and is 0 otherwise while `init_done` is 1.
- R4: `ser_o` gives the latched byte most significant bit first. It shows bit 7 in the cycle after the latching edge, and the lower bits one per following cycle down to bit 0.
- R5: `chain_o` changes only on falling edges. It carries the `ser_o` value of the previous clock cycle, so a bit latched on a rising edge appears on `chain_o` 1.5 clock periods later.
- R6: `done_o` becomes 1 after the (10 + chain length)-th rising edge that follows the last latching edge, with no latch in between. It then stays 1 until reset or the next latch.
- R7: The chain length is taken from `chain_len` while `rst` is high. Changes on `chain_len` outside reset have no effect.
- R8: While `mode_sel` is not 011, `cfg_data` is ignored. No byte is latched, `ack_o` and `byte_stb` stay 0, and `ser_o` and `chain_o` stay 0 when no byte is in flight.
- R9: While `init_done` is 0, `ack_o` reads 1 (the line rests high) and no byte is latched.
- R10: Once the last bit of a byte has been shifted out and no new byte is latched, `ser_o` shows 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock supplied by the host |
| rst | input | 1 | Synchronous active-high reset; also loads the chain length |
| cfg_data | input | 8 | Byte-wide configuration data bus |
| mode_sel | input | 3 | Mode select; 011 enables the port |
| init_done | input | 1 | Initialisation complete; gates the port and the acknowledge |
| chain_len | input | DEPTH_W (4) | Number of downstream devices, read during reset |
| ack_o | output | 1 | One-cycle acknowledge after each latched byte; 1 while `init_done` is 0 |
| ser_o | output | 1 | Serial data, most significant bit first, timed to the rising edge |
| chain_o | output | 1 | Serial data retimed to the falling edge for the next device |
| byte_stb | output | 1 | High in a cycle whose closing rising edge latches the bus |
| done_o | output | 1 | Shift completion flag after the tail count |

## Verification
The bench sweeps several chain lengths, including the largest one. In each pass it streams a run of distinct bytes and compares every output in every cycle against a model built from the edge index.

It looks closely at the edge where the flag rises. A tail counter off by one would raise `done_o` a cycle early or late. A count that ignored the chain length would raise it at edge ten for every pass.

It also checks the falling-edge copy against the previous cycle's serial bit. Retiming on the rising edge, or skipping the extra stage, would put `chain_o` a cycle out of step.

Finally, it holds the port with `init_done` low, then with a wrong mode, while the bus carries all ones. A design that latched anyway would show stray ones on `ser_o` or a stray acknowledge. The bench also checks that the serial line returns to zero after the last byte, which catches a shifter that refills with ones or reloads a stale byte.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    localparam int          BYTE_W      = 8;
    localparam logic [2:0]  MODE_ENABLE = 3'b011;
    localparam int          TAIL_BASE   = 10;

    typedef logic [BYTE_W-1:0] byte_t;

    // State of the completion tracker
    typedef struct packed {
        logic       loaded;
        logic [7:0] count;
    } tail_state_t;

    function automatic logic port_enabled(input logic [2:0] mode, input logic init);
        return init && (mode == MODE_ENABLE);
    endfunction

endpackage

// File: rtl/cfgser_ctrl.sv
module cfgser_ctrl
    import cfgser_pkg::*;
#(
    parameter int CNT_W = $clog2(BYTE_W)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_sel,
    input  logic       init_done,
    output logic       capture,
    output logic       ack_q
);

    logic [CNT_W-1:0] bit_pos;
    logic             enabled;
    logic             advance;

    assign enabled = port_enabled(mode_sel, init_done);
    assign capture = enabled && (bit_pos == '0);
    // Keep counting to finish a byte in flight even if the port is dropped
    assign advance = enabled || (bit_pos != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_pos <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= capture;
            if (advance) begin
                if (bit_pos == CNT_W'(BYTE_W - 1))
                    bit_pos <= '0;
                else
                    bit_pos <= bit_pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfgser_shift.sv
module cfgser_shift
    import cfgser_pkg::*;
#(
    parameter int RISE_STAGES = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  capture,
    input  byte_t data_in,
    output logic  ser_o,
    output logic  chain_o
);

    byte_t shreg;
    logic [RISE_STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst)
            shreg <= '0;
        else if (capture)
            shreg <= data_in;
        else
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
    end

    assign ser_o   = shreg[BYTE_W-1];
    assign pipe[0] = ser_o;

    // Rising-edge delay stages ahead of the falling-edge retime
    for (genvar s = 0; s < RISE_STAGES; s++) begin : g_rise
        always_ff @(posedge clk) begin
            if (rst)
                pipe[s+1] <= 1'b0;
            else
                pipe[s+1] <= pipe[s];
        end
    end

    always_ff @(negedge clk) begin
        if (rst)
            chain_o <= 1'b0;
        else
            chain_o <= pipe[RISE_STAGES];
    end

endmodule

// File: rtl/cfgser_tail.sv
module cfgser_tail
    import cfgser_pkg::*;
#(
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [DEPTH_W-1:0] chain_len,
    output logic               done_o
);

    localparam int TW = $clog2(TAIL_BASE + (1 << DEPTH_W)) + 1;
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [DEPTH_W-1:0] depth_q;
    logic               loaded;
    logic [TW-1:0]      count;
    logic [TW-1:0]      limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= chain_len;
            loaded  <= 1'b0;
            count   <= '0;
        end else if (capture) begin
            loaded  <= 1'b1;
            count   <= '0;
        end else if (loaded && (count != CNT_MAX)) begin
            count   <= count + 1'b1;
        end
    end

    assign limit  = TW'(TAIL_BASE) + TW'(depth_q);
    assign done_o = loaded && (count >= limit);

endmodule

// File: rtl/cfgser_top.sv
module cfgser_top
    import cfgser_pkg::*;
#(
    parameter int DEPTH_W     = 4,
    parameter int RISE_STAGES = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         cfg_data,
    input  logic [2:0]         mode_sel,
    input  logic               init_done,
    input  logic [DEPTH_W-1:0] chain_len,
    output logic               ack_o,
    output logic               ser_o,
    output logic               chain_o,
    output logic               byte_stb,
    output logic               done_o
);

    logic capture;
    logic ack_q;

    cfgser_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .init_done (init_done),
        .capture   (capture),
        .ack_q     (ack_q)
    );

    cfgser_shift #(.RISE_STAGES(RISE_STAGES)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .data_in (cfg_data),
        .ser_o   (ser_o),
        .chain_o (chain_o)
    );

    cfgser_tail #(.DEPTH_W(DEPTH_W)) u_tail (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .chain_len (chain_len),
        .done_o    (done_o)
    );

    assign byte_stb = capture;
    // Line rests high until initialisation completes
    assign ack_o    = init_done ? ack_q : 1'b1;

endmodule

// File: rtl/cfgser_chk.sv
module cfgser_chk (
    input logic clk,
    input logic rst,
    input logic init_done,
    input logic ack_o,
    input logic ser_o,
    input logic chain_o,
    input logic byte_stb,
    input logic done_o
);

    AST_ACK_FOLLOWS_STB: assert property (@(posedge clk) disable iff (rst)
        byte_stb |=> ack_o);                                          // R2

    AST_STB_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        byte_stb |=> !byte_stb);                                      // R2

    AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (init_done && ack_o) |=> (!init_done || !ack_o));             // R3

    AST_CHAIN_LAGS_SER: assert property (@(posedge clk) disable iff (rst)
        chain_o == $past(ser_o));                                     // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done_o && !byte_stb) |=> done_o);                            // R6

    AST_NO_ACK_WITHOUT_STB: assert property (@(posedge clk) disable iff (rst)
        !byte_stb |=> (!init_done || !ack_o));                        // R8

endmodule

bind cfgser_top cfgser_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .init_done (init_done),
    .ack_o     (ack_o),
    .ser_o     (ser_o),
    .chain_o   (chain_o),
    .byte_stb  (byte_stb),
    .done_o    (done_o)
);

// File: tb/tb_cfgser_top.sv
module tb_cfgser_top;

    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 5;
    localparam int DEPTH_W    = 4;
    localparam int WATCHDOG   = 20000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [7:0]         cfg_data = '0;
    logic [2:0]         mode_sel = '0;
    logic               init_done = 1'b1;
    logic [DEPTH_W-1:0] chain_len = '0;
    logic ack_o, ser_o, chain_o, byte_stb, done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] bseq [NBYTES];

    cfgser_top #(.DEPTH_W(DEPTH_W)) dut (
        .clk(clk), .rst(rst), .cfg_data(cfg_data), .mode_sel(mode_sel),
        .init_done(init_done), .chain_len(chain_len), .ack_o(ack_o),
        .ser_o(ser_o), .chain_o(chain_o), .byte_stb(byte_stb), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Serial bit expected after rising edge e (edge 0 = first latch)
    function automatic int exp_ser(input int e);
        if (e < 0 || e / 8 >= NBYTES) return 0;
        return int'(bseq[e / 8][7 - (e % 8)]);
    endfunction

    task automatic run_pass(input int depth);
        int last_e;
        last_e = 8 * (NBYTES - 1);
        for (int i = 0; i < NBYTES; i++)
            bseq[i] = 8'((i * 73 + depth * 29 + 8'h5A) & 8'hFF);

        // Reset, chain length sampled here (R7)
        @(posedge clk); #2;
        rst = 1'b1; mode_sel = 3'b000; init_done = 1'b1;
        chain_len = DEPTH_W'(depth); cfg_data = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); #3;
        chk("R1 ser", ser_o, 0);
        chk("R1 chain", chain_o, 0);
        chk("R1 ack", ack_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 stb", byte_stb, 0);

        // Init low with enabling mode: ack rests high, nothing latched (R9)
        @(posedge clk); #2;
        rst = 1'b0; init_done = 1'b0; mode_sel = 3'b011; cfg_data = 8'hFF;
        chain_len = DEPTH_W'(depth ^ 1);  // ignored outside reset (R7)
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #3;
            chk("R9 ack high", ack_o, 1);
            chk("R9 no latch ser", ser_o, 0);
            chk("R9 stb", byte_stb, 0);
            chk("R1 after reset chain", chain_o, 0);
            @(posedge clk); #2;
        end

        // Wrong mode: bus ignored (R8)
        init_done = 1'b1; mode_sel = 3'b001;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #3;
            chk("R8 ack", ack_o, 0);
            chk("R8 ser", ser_o, 0);
            chk("R8 chain", chain_o, 0);
            chk("R8 stb", byte_stb, 0);
            chk("R8 done", done_o, 0);
            @(posedge clk); #2;
        end

        // Stream
        mode_sel = 3'b011; cfg_data = bseq[0];
        @(negedge clk); #3;
        chk("R2 first stb", byte_stb, 1);
        for (int e = 0; e <= last_e + 10 + depth + 3; e++) begin
            @(posedge clk); #2;
            if (((e + 1) % 8 == 0) && ((e + 1) / 8 < NBYTES))
                cfg_data = bseq[(e + 1) / 8];
            if (e == last_e) begin
                mode_sel = 3'b000;
                cfg_data = 8'hFF;
            end
            @(negedge clk); #3;
            chk((e / 8 < NBYTES) ? "R4 ser" : "R10 ser idle", ser_o, exp_ser(e));
            chk("R5 chain", chain_o, exp_ser(e - 1));
            chk("R3 ack", ack_o, int'((e % 8 == 0) && (e / 8 < NBYTES)));
            chk("R2 stb", byte_stb, int'(((e + 1) % 8 == 0) && ((e + 1) / 8 < NBYTES)));
            chk("R6 done", done_o, int'((e - last_e) >= 10 + depth));
        end
    endtask

    initial begin
        run_pass(0);
        run_pass(1);
        run_pass(2);
        run_pass(3);
        run_pass((1 << DEPTH_W) - 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule